// File: doc/BRIEF.md
# 8-bit Accumulator Processor with Relayed Fetch and Execute

A small register-memory processor that runs programs out of a single 256-byte memory through one shared port. The read port is synchronous: data comes back one cycle after the read strobe. Its visible state is a program counter, an accumulator A, an address register X and a carry flag C. It also holds an opcode register, an operand register and a memory-data register.

Two sequencers cooperate. The fetch sequencer reads the opcode byte. When bit 7 of that byte is set, it also reads one operand byte. It then hands the instruction to the execute sequencer and goes idle. The execute sequencer performs the instruction and hands control back to fetch.

The two memory-operand ALU instructions are handled differently. Execute gives control back to fetch as soon as the operand byte arrives. The final ALU cycle then runs alongside the address cycle of the next fetch. Execution begins when the start input is pulsed while both sequencers are idle.

Top module: `tiny_acc_cpu`

## Requirements
- R1: Reset behaviour.
  - After reset, the program counter, A, X and C are all zero.
  - No read or write strobe is raised until start is accepted.
- R2: Fetch timing.
  - Start is accepted while both sequencers are idle. The opcode read at the program counter is strobed in the cycle after the start cycle.
  - If bit 7 of the returned opcode is set, the operand read at PC+1 is strobed in the next cycle.
  - A one-byte instruction's memory access falls in the third cycle after start. A two-byte instruction's access falls in the fourth.
- R3: Opcodes and effects. Each opcode is a byte value.
  - 0x00: no operation.
  - 0x01: A <= M[X].
  - 0x02: M[X] <= A.
  - 0x03: X <= A.
  - 0x04: A <= X.
  - 0x05: X <= X+1.
  - 0x06: A <= ~A.
  - 0x07: C <= 1.
  - 0x08: C <= 0.
  - 0x0B: add with carry from M[X].
  - 0x0C: AND with M[X].
  - 0x81: A <= operand.
  - 0x83: X <= operand.
  - 0x84: X <= M[operand].
  - 0x85: M[operand] <= X.
  - 0x8D: branch on carry.
- R4: ALU instructions.
  - 0x0B computes A <= A + M[X] + C, and C takes the carry out of bit 7.
  - 0x0C computes A <= A & M[X] and leaves C unchanged.
- R5: Overlap of the ALU instructions.
  - For 0x0B and 0x0C, the next opcode read is strobed in the same cycle that A is updated.
  - A store that follows 0x01, 0x0B or 0x0C writes in the seventh cycle after start, and the written value already holds the new A.
- R6: Branch on carry.
  - 0x8D loads the program counter from the operand when C is 1.
  - When C is 0, execution continues with the next instruction.
- R7: Port discipline.
  - Read and write are never strobed in the same cycle.
  - Fetch and execute never use the memory port in the same cycle.
- R8: Undefined opcodes.
  - Any unlisted opcode changes no register and no memory.
  - When its bit 7 is set, it still consumes one operand byte.
- R9: A start pulse while an instruction is in flight is ignored.
- R10: The reference program gives the expected result.
  - The program is LDXI FD, LDAX, CLC, LDXI FE, ADCX, LDXI FF, STAX, SEC, BC 0B.
  - With 0x12 at 0xFD and 0x34 at 0xFE, it stores 0x46 at 0xFF and then loops on itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution when idle |
| mem_addr | output | 8 | Memory address, valid with a strobe |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data from the previous cycle's read |

## Verification
The bound checker watches several properties on every cycle:
- Fetch and execute never share the memory port, and read and write strobes stay exclusive.
- The program counter steps on each opcode address cycle, and a set opcode bit 7 leads to an operand cycle.
- Every handoff lands in the other sequencer, and the ALU cycle of 0x0B and 0x0C coincides with the next fetch address cycle.
- An idle machine raises no strobe, and start is ignored while running.

Arithmetic results, branch outcomes, undefined-opcode handling and exact cycle counts are only visible through the bench's programs. These include timed store probes, directed dumps of A, X and C to memory, and random programs compared byte for byte against an instruction-level model.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned WORD_W = 8;
  typedef logic [WORD_W-1:0] word_t;

  // opcode table: bit 7 set means one operand byte follows
  localparam word_t OP_NOP  = 8'h00;
  localparam word_t OP_LDAX = 8'h01;
  localparam word_t OP_STAX = 8'h02;
  localparam word_t OP_TAX  = 8'h03;
  localparam word_t OP_TXA  = 8'h04;
  localparam word_t OP_INX  = 8'h05;
  localparam word_t OP_NOTA = 8'h06;
  localparam word_t OP_SEC  = 8'h07;
  localparam word_t OP_CLC  = 8'h08;
  localparam word_t OP_ADCX = 8'h0B;
  localparam word_t OP_ANDX = 8'h0C;
  localparam word_t OP_LDAI = 8'h81;
  localparam word_t OP_LDXI = 8'h83;
  localparam word_t OP_LDXM = 8'h84;
  localparam word_t OP_STXM = 8'h85;
  localparam word_t OP_BC   = 8'h8D;

  typedef enum logic [1:0] {F_IDLE, F_ADDR, F_OPC, F_OPND} fetch_st_t;
  typedef enum logic [1:0] {E_IDLE, E_ISSUE, E_LOAD, E_ALU} exec_st_t;

  typedef enum logic [2:0] {A_HOLD, A_RDATA, A_OPND, A_XREG, A_NOT, A_ADC, A_AND} a_src_t;
  typedef enum logic [2:0] {X_HOLD, X_RDATA, X_OPND, X_AREG, X_INC} x_src_t;
  typedef enum logic [1:0] {C_HOLD, C_CLR, C_SET, C_CARRY} c_src_t;

  typedef struct packed {
    a_src_t a_src;
    x_src_t x_src;
    c_src_t c_src;
    logic   md_we;
    logic   pc_jump;
  } dp_ctl_t;

  // sum with carry-out in the top bit
  function automatic logic [WORD_W:0] add_with_carry(word_t a, word_t b, logic ci);
    return {1'b0, a} + {1'b0, b} + {{WORD_W{1'b0}}, ci};
  endfunction

  function automatic word_t mask_and(word_t a, word_t b);
    return a & b;
  endfunction

  function automatic logic is_alu_mem(word_t op);
    return (op == OP_ADCX) || (op == OP_ANDX);
  endfunction
endpackage

// File: rtl/acc_fetch_fsm.sv
module acc_fetch_fsm
  import acc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  logic      opc_msb,
  output fetch_st_t state,
  output logic      bus_rd,
  output logic      pc_inc,
  output logic      opc_we,
  output logic      opnd_we,
  output logic      handoff
);
  fetch_st_t nxt;

  always_comb begin
    nxt     = state;
    bus_rd  = 1'b0;
    pc_inc  = 1'b0;
    opc_we  = 1'b0;
    opnd_we = 1'b0;
    handoff = 1'b0;
    case (state)
      F_IDLE: if (go) nxt = F_ADDR;
      F_ADDR: begin
        bus_rd = 1'b1;
        pc_inc = 1'b1;
        nxt    = F_OPC;
      end
      F_OPC: begin
        opc_we = 1'b1;
        if (opc_msb) begin
          bus_rd = 1'b1;
          pc_inc = 1'b1;
          nxt    = F_OPND;
        end else begin
          handoff = 1'b1;
          nxt     = F_IDLE;
        end
      end
      F_OPND: begin
        opnd_we = 1'b1;
        handoff = 1'b1;
        nxt     = F_IDLE;
      end
      default: nxt = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= F_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/acc_exec_fsm.sv
module acc_exec_fsm
  import acc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  word_t    op,
  output exec_st_t state,
  output logic     bus_rd,
  output logic     bus_wr,
  output logic     addr_x,
  output logic     wr_a,
  output logic     relay,
  output dp_ctl_t  ctl
);
  exec_st_t nxt;

  always_comb begin
    nxt    = state;
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    addr_x = 1'b1;
    wr_a   = 1'b1;
    relay  = 1'b0;
    ctl    = '{a_src: A_HOLD, x_src: X_HOLD, c_src: C_HOLD, md_we: 1'b0, pc_jump: 1'b0};
    case (state)
      E_IDLE: if (go) nxt = E_ISSUE;
      E_ISSUE: begin
        nxt   = E_IDLE;
        relay = 1'b1;
        case (op)
          OP_LDAX, OP_ADCX, OP_ANDX: begin
            bus_rd = 1'b1;
            relay  = 1'b0;
            nxt    = E_LOAD;
          end
          OP_LDXM: begin
            bus_rd = 1'b1;
            addr_x = 1'b0;
            relay  = 1'b0;
            nxt    = E_LOAD;
          end
          OP_STAX: bus_wr = 1'b1;
          OP_STXM: begin
            bus_wr = 1'b1;
            addr_x = 1'b0;
            wr_a   = 1'b0;
          end
          OP_TAX:  ctl.x_src   = X_AREG;
          OP_TXA:  ctl.a_src   = A_XREG;
          OP_INX:  ctl.x_src   = X_INC;
          OP_NOTA: ctl.a_src   = A_NOT;
          OP_SEC:  ctl.c_src   = C_SET;
          OP_CLC:  ctl.c_src   = C_CLR;
          OP_LDAI: ctl.a_src   = A_OPND;
          OP_LDXI: ctl.x_src   = X_OPND;
          OP_BC:   ctl.pc_jump = 1'b1;
          default: ;
        endcase
      end
      E_LOAD: begin
        relay = 1'b1;
        if (is_alu_mem(op)) begin
          ctl.md_we = 1'b1;
          nxt       = E_ALU;
        end else begin
          nxt = E_IDLE;
          if (op == OP_LDXM) ctl.x_src = X_RDATA;
          else               ctl.a_src = A_RDATA;
        end
      end
      E_ALU: begin
        nxt = E_IDLE;
        if (op == OP_ADCX) begin
          ctl.a_src = A_ADC;
          ctl.c_src = C_CARRY;
        end else begin
          ctl.a_src = A_AND;
        end
      end
      default: nxt = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= E_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter word_t PC_RESET = '0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pc_inc,
  input  logic    opc_we,
  input  logic    opnd_we,
  input  dp_ctl_t ctl,
  input  word_t   rdata,
  output word_t   pc,
  output word_t   a,
  output word_t   x,
  output logic    c,
  output word_t   op,
  output word_t   opnd,
  output logic    carry_out
);
  logic [WORD_W:0] sum;
  word_t md;

  assign sum       = add_with_carry(a, md, c);
  assign carry_out = sum[WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= PC_RESET;
      a    <= '0;
      x    <= '0;
      c    <= 1'b0;
      op   <= '0;
      opnd <= '0;
      md   <= '0;
    end else begin
      if (ctl.pc_jump && c) pc <= opnd;
      else if (pc_inc)      pc <= pc + 1'b1;
      if (opc_we)    op   <= rdata;
      if (opnd_we)   opnd <= rdata;
      if (ctl.md_we) md   <= rdata;
      case (ctl.a_src)
        A_RDATA: a <= rdata;
        A_OPND:  a <= opnd;
        A_XREG:  a <= x;
        A_NOT:   a <= ~a;
        A_ADC:   a <= sum[WORD_W-1:0];
        A_AND:   a <= mask_and(a, md);
        default: ;
      endcase
      case (ctl.x_src)
        X_RDATA: x <= rdata;
        X_OPND:  x <= opnd;
        X_AREG:  x <= a;
        X_INC:   x <= x + 1'b1;
        default: ;
      endcase
      case (ctl.c_src)
        C_CLR:   c <= 1'b0;
        C_SET:   c <= 1'b1;
        C_CARRY: c <= carry_out;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tiny_acc_cpu.sv
module tiny_acc_cpu
  import acc_pkg::*;
#(
  parameter word_t PC_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  fetch_st_t f_state;
  exec_st_t  e_state;
  logic f_bus_rd, f_pc_inc, f_opc_we, f_opnd_we, f_handoff;
  logic e_bus_rd, e_bus_wr, e_addr_x, e_wr_a, e_relay;
  dp_ctl_t ctl;
  word_t pc, a_reg, x_reg, op, opnd;
  logic c_flag, carry_out;

  // named events for the checker
  logic both_idle, start_take, fetch_go, overlap_fire;
  assign both_idle    = (f_state == F_IDLE) && (e_state == E_IDLE);
  assign start_take   = start && both_idle;
  assign fetch_go     = start_take || e_relay;
  assign overlap_fire = (e_state == E_LOAD) && is_alu_mem(op);

  acc_fetch_fsm u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (fetch_go),
    .opc_msb (mem_rdata[WORD_W-1]),
    .state   (f_state),
    .bus_rd  (f_bus_rd),
    .pc_inc  (f_pc_inc),
    .opc_we  (f_opc_we),
    .opnd_we (f_opnd_we),
    .handoff (f_handoff)
  );

  acc_exec_fsm u_exec (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (f_handoff),
    .op     (op),
    .state  (e_state),
    .bus_rd (e_bus_rd),
    .bus_wr (e_bus_wr),
    .addr_x (e_addr_x),
    .wr_a   (e_wr_a),
    .relay  (e_relay),
    .ctl    (ctl)
  );

  acc_datapath #(.PC_RESET(PC_RESET)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_inc    (f_pc_inc),
    .opc_we    (f_opc_we),
    .opnd_we   (f_opnd_we),
    .ctl       (ctl),
    .rdata     (mem_rdata),
    .pc        (pc),
    .a         (a_reg),
    .x         (x_reg),
    .c         (c_flag),
    .op        (op),
    .opnd      (opnd),
    .carry_out (carry_out)
  );

  // fetch owns the port whenever it strobes; otherwise execute picks X or operand
  assign mem_addr  = f_bus_rd ? pc : (e_addr_x ? x_reg : opnd);
  assign mem_rd    = f_bus_rd || e_bus_rd;
  assign mem_wr    = e_bus_wr;
  assign mem_wdata = e_wr_a ? a_reg : x_reg;
endmodule

module acc_cpu_chk
  import acc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      start,
  input fetch_st_t f_state,
  input exec_st_t  e_state,
  input logic      f_bus_rd,
  input logic      e_bus_rd,
  input logic      e_bus_wr,
  input logic      f_handoff,
  input logic      overlap_fire,
  input logic      rd_msb,
  input logic      mem_rd,
  input logic      mem_wr,
  input word_t     pc
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (f_state == F_IDLE && e_state == E_IDLE) |-> (!mem_rd && !mem_wr));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (f_state == F_ADDR) |=> (pc == 8'($past(pc) + 8'd1)));

  p_opnd_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (f_state == F_OPC && rd_msb) |=> (f_state == F_OPND));

  p_handoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    f_handoff |=> (e_state == E_ISSUE));

  p_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_fire |=> (e_state == E_ALU && f_state == F_ADDR));

  p_alu_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (e_state == E_ALU) |-> (!e_bus_rd && !e_bus_wr));

  p_port_share_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_bus_rd && (e_bus_rd || e_bus_wr)));

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && f_state == F_OPND) |=> (f_state == F_IDLE));
endmodule

bind tiny_acc_cpu acc_cpu_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .f_state      (f_state),
  .e_state      (e_state),
  .f_bus_rd     (f_bus_rd),
  .e_bus_rd     (e_bus_rd),
  .e_bus_wr     (e_bus_wr),
  .f_handoff    (f_handoff),
  .overlap_fire (overlap_fire),
  .rd_msb       (mem_rdata[7]),
  .mem_rd       (mem_rd),
  .mem_wr       (mem_wr),
  .pc           (pc)
);

// File: tb/tiny_acc_cpu_tb.sv
module tiny_acc_cpu_tb;
  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] mem_addr, mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic mem_rd, mem_wr;

  logic [7:0] mem [256];
  logic [7:0] img [256];
  logic [7:0] mdl [256];
  int plen;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiny_acc_cpu u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // synchronous memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] ref_adc(input logic [7:0] a, input logic [7:0] b, input logic ci);
    int s;
    s = int'(a) + int'(b) + (ci ? 1 : 0);
    return s[8:0];
  endfunction

  // instruction-level reference model working on mdl
  task automatic run_model(input int end_pc);
    logic [7:0] pc = 8'h00, a = 8'h00, x = 8'h00, op, opr;
    logic c = 1'b0;
    logic [8:0] s;
    for (int step = 0; step < 2000 && pc != end_pc[7:0]; step++) begin
      op = mdl[pc]; pc = pc + 8'd1; opr = 8'h00;
      if (op[7]) begin opr = mdl[pc]; pc = pc + 8'd1; end
      case (op)
        8'h01: a = mdl[x];
        8'h02: mdl[x] = a;
        8'h03: x = a;
        8'h04: a = x;
        8'h05: x = x + 8'd1;
        8'h06: a = ~a;
        8'h07: c = 1'b1;
        8'h08: c = 1'b0;
        8'h0B: begin s = ref_adc(a, mdl[x], c); a = s[7:0]; c = s[8]; end
        8'h0C: a = a & mdl[x];
        8'h81: a = opr;
        8'h83: x = opr;
        8'h84: x = mdl[opr];
        8'h85: mdl[opr] = x;
        8'h8D: if (c) pc = opr;
        default: ;
      endcase
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = (i >= 8'hC0) ? 8'($urandom_range(0, 255)) : 8'h00;
    plen = 0;
  endtask

  task automatic put(input logic [7:0] b);
    img[plen] = b;
    plen++;
  endtask

  // X to F0, A to F1, carry marker to F2 (0 when C set, 1 when clear), then self loop
  task automatic put_dump(output int end_pc);
    int p;
    p = plen;
    put(8'h85); put(8'hF0); put(8'h83); put(8'hF1); put(8'h02);
    put(8'h81); put(8'h00); put(8'h8D); put(8'(p + 11)); put(8'h81); put(8'h01);
    put(8'h83); put(8'hF2); put(8'h02); put(8'h07); put(8'h8D); put(8'(p + 15));
    end_pc = p + 15;
  endtask

  task automatic load_reset();
    rst_n = 1'b0;
    start = 1'b0;
    for (int i = 0; i < 256; i++) begin mem[i] = img[i]; mdl[i] = img[i]; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_prog(input int end_pc, input int cycles, input bit restarts);
    load_reset();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      start = (restarts && (k % 17 == 5)) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    run_model(end_pc);
  endtask

  task automatic compare_mem(input string req, input string what);
    int bad = -1;
    for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== mdl[i]) bad = i;
    if (bad < 0) chk(req, what, 32'd0, 32'd0);
    else chk(req, $sformatf("%s byte %0h", what, bad), {24'd0, mem[bad]}, {24'd0, mdl[bad]});
  endtask

  // img already built; counts cycles from start to the first write strobe
  task automatic measure(input string req, input int exp_n, input logic [7:0] exp_w);
    int n;
    load_reset();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    chk("R2", "first opcode read at pc 0", {23'd0, mem_rd, mem_addr}, {23'd0, 1'b1, 8'h00});
    while (!mem_wr && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(req, "write cycle", n, exp_n);
    chk(req, "write data", {24'd0, mem_wdata}, {24'd0, exp_w});
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int endp;
    bit quiet;
    void'($urandom(32'd20240611));

    // R1: idle after reset, no strobes
    clear_img();
    put(8'h02);
    load_reset();
    quiet = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (mem_rd || mem_wr) quiet = 1'b0;
    end
    chk("R1", "no strobe before start", {31'd0, quiet}, 32'd1);

    // R1 reset A and X are zero: lone store writes 0 to address 0 in cycle 3
    clear_img();
    put(8'h02);
    measure("R1", 3, 8'h00);
    chk("R1", "store address X", {24'd0, mem_addr}, 32'h0);

    // R2: two-byte instruction then store
    clear_img();
    put(8'h81); put(8'h05); put(8'h02);
    measure("R2", 7, 8'h05);

    // R5: load vs overlapped ALU ops followed by a store
    clear_img();
    put(8'h01); put(8'h02);
    measure("R5", 7, 8'h01);
    clear_img();
    put(8'h0B); put(8'h02);
    measure("R5", 7, 8'h0B);
    clear_img();
    put(8'h0C); put(8'h02);
    measure("R5", 7, 8'h00);

    // R10 with R9: reference program, start pulses while running
    clear_img();
    put(8'h83); put(8'hFD); put(8'h01); put(8'h08); put(8'h83); put(8'hFE);
    put(8'h0B); put(8'h83); put(8'hFF); put(8'h02); put(8'h07); put(8'h8D); put(8'h0B);
    img[8'hFD] = 8'h12; img[8'hFE] = 8'h34; img[8'hFF] = 8'h00;
    run_prog(8'h0B, 200, 1'b1);
    chk("R10", "sum at FF", {24'd0, mem[8'hFF]}, 32'h46);
    compare_mem("R9", "memory after ignored starts");

    // R4 and R6: add with carry-in, carry out set, branch taken
    clear_img();
    put(8'h81); put(8'hF0); put(8'h83); put(8'hC0); put(8'h07); put(8'h0B);
    img[8'hC0] = 8'h20;
    put_dump(endp);
    run_prog(endp, 300, 1'b0);
    chk("R4", "adc result", {24'd0, mem[8'hF1]}, 32'h11);
    chk("R6", "carry set marker", {24'd0, mem[8'hF2]}, 32'h00);

    // R4 and R6: add without carry, branch not taken
    clear_img();
    put(8'h81); put(8'h10); put(8'h83); put(8'hC0); put(8'h08); put(8'h0B);
    img[8'hC0] = 8'h20;
    put_dump(endp);
    run_prog(endp, 300, 1'b0);
    chk("R4", "adc no carry", {24'd0, mem[8'hF1]}, 32'h30);
    chk("R6", "carry clear marker", {24'd0, mem[8'hF2]}, 32'h01);

    // R4: AND keeps carry
    clear_img();
    put(8'h81); put(8'hF0); put(8'h83); put(8'hC0); put(8'h07); put(8'h0C);
    img[8'hC0] = 8'h3C;
    put_dump(endp);
    run_prog(endp, 300, 1'b0);
    chk("R4", "and result", {24'd0, mem[8'hF1]}, 32'h30);
    chk("R4", "and keeps carry", {24'd0, mem[8'hF2]}, 32'h00);

    // R8: undefined opcodes, one of them swallowing a SEC byte
    clear_img();
    put(8'h08); put(8'h81); put(8'h05); put(8'h0F); put(8'h9F); put(8'h07);
    put_dump(endp);
    run_prog(endp, 300, 1'b0);
    chk("R8", "A unchanged", {24'd0, mem[8'hF1]}, 32'h05);
    chk("R8", "operand consumed", {24'd0, mem[8'hF2]}, 32'h01);

    // R3: register transfers, memory load of X
    clear_img();
    put(8'h81); put(8'hD4); put(8'h03); put(8'h02); put(8'h84); put(8'hC5); put(8'h05);
    img[8'hC5] = 8'hE3;
    put_dump(endp);
    run_prog(endp, 300, 1'b0);
    chk("R3", "store via transferred X", {24'd0, mem[8'hD4]}, 32'hD4);
    chk("R3", "X from memory plus one", {24'd0, mem[8'hF0]}, 32'hE4);
    compare_mem("R3", "directed transfer program");

    // R3: random programs against the model
    for (int t = 0; t < 30; t++) begin
      int cnt;
      clear_img();
      put(8'h83); put(8'(8'hC0 + $urandom_range(0, 31)));
      cnt = $urandom_range(8, 24);
      for (int j = 0; j < cnt; j++) begin
        case ($urandom_range(0, 12))
          0:  put(8'h00);
          1:  put(8'h01);
          2:  put(8'h02);
          3:  put(8'h04);
          4:  put(8'h05);
          5:  put(8'h06);
          6:  put(8'h07);
          7:  put(8'h08);
          8:  put(8'h0B);
          9:  put(8'h0C);
          10: begin put(8'h81); put(8'($urandom_range(0, 255))); end
          11: begin put(8'h83); put(8'(8'hC0 + $urandom_range(0, 31))); end
          default: begin put(8'h85); put(8'(8'hC0 + $urandom_range(0, 47))); end
        endcase
      end
      put_dump(endp);
      run_prog(endp, 400, 1'b0);
      compare_mem("R3", $sformatf("random program %0d", t));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule